// File: doc/BRIEF.md
# Peripheral Identifier Translation Table

This block keeps a programmable table that relates the 12-bit identifiers used on a power-management serial bus to the compact 8-bit identifiers used inside the bus arbiter. Software-side logic programs one pair at a time: an arbiter id and the peripheral id that belongs to it. Each accepted write marks its entry valid. It also widens the tracked window of programmed arbiter ids, held as a low bound and a high bound.

Two lookups are offered. The forward direction is a plain indexed read: present an arbiter id and the stored peripheral id and its valid flag appear combinationally. The reverse direction is a search. Given a peripheral id and a start pulse, the block walks the arbiter ids one per clock, from the low bound up to the high bound, and stops at the first valid entry that matches. It reports that arbiter id, or the value 256 when nothing matches. The result stays on the outputs until the next accepted start. Table writes are held off while a search runs, so the table and its bounds stay fixed for the whole walk.

Top module: `idx_xlate_top`

## Requirements
- R1: After reset every entry is zero (invalid, peripheral id 0), the low bound is 255, the high bound is 0, wrErr, wrDup, revBusy, revDone and revHit are 0, revAid is 0 and wrReady is 1.
- R2: A legal accepted write of arbiter id A and peripheral id P stores P with the valid flag in bit 15 of a 16-bit entry, bits 14:12 zero. From the next cycle, fwdAid = A gives fwdPid = P and fwdValid = 1. P carries a 4-bit slave address in bits 11:8 and an 8-bit peripheral number in bits 7:0; the table treats it as one 12-bit key.
- R3: Every legal accepted write lowers loAid to A when A is below it and raises hiAid to A when A is above it.
- R4: A legal write to an arbiter id whose entry is already valid replaces the stored peripheral id and sets wrDup. wrDup is 0 for a write to an invalid entry. wrDup and wrErr are updated on every accepted write and hold until the next one.
- R5: A write with wrAid above 0xFF or wrPid above 0xFFF is rejected. It sets wrErr and leaves the table, loAid and hiAid unchanged.
- R6: An accepted revStart searches arbiter ids from loAid upward, one per clock. On the first valid entry whose peripheral id equals revPid, it sets revDone and revHit and puts that arbiter id on revAid. revDone rises (A - loAid + 1) cycles after the start edge, and the lowest matching arbiter id wins.
- R7: A search that reaches hiAid without a match ends with revAid = 256 and revHit = 0, (hiAid - loAid + 1) cycles after the start edge. With an empty table (loAid > hiAid) it ends at the start edge itself.
- R8: revBusy is 1 from the start edge until the result edge. The result holds until the next accepted start. A revStart while revBusy is 1 is ignored.
- R9: wrReady is 0 while revBusy is 1 or while revStart is high. A write offered while wrReady is 0 has no effect.
- R10: Entries inside the searched window that were never programmed do not match, even when revPid equals their stored value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Program request |
| wrAid | input | 9 | Arbiter id to program (values above 0xFF are illegal) |
| wrPid | input | 16 | Peripheral id to program (values above 0xFFF are illegal) |
| wrReady | output | 1 | Program request is accepted this cycle |
| wrErr | output | 1 | Last accepted write was rejected as out of range |
| wrDup | output | 1 | Last accepted write overwrote a valid entry |
| fwdAid | input | 8 | Forward lookup index |
| fwdPid | output | 12 | Peripheral id stored at fwdAid |
| fwdValid | output | 1 | Entry at fwdAid is valid |
| revStart | input | 1 | Start a reverse search |
| revPid | input | 12 | Peripheral id to search for |
| revBusy | output | 1 | Reverse search in progress |
| revDone | output | 1 | Reverse search result available |
| revHit | output | 1 | Result is a match |
| revAid | output | 9 | Matching arbiter id, or 256 on a miss |
| loAid | output | 8 | Lowest programmed arbiter id |
| hiAid | output | 8 | Highest programmed arbiter id |

## Verification
The hardest case to reach is a stimulus that lands while a search is walking. Examples are a write offered in the middle of a long scan, a write offered in the same cycle as the start, and a second start pulse during a scan. The stimulus builds a window of 177 arbiter ids so the walk lasts long enough to inject each of these at a fixed cycle. Afterwards it reads those arbiter ids through the forward port and confirms the first search's result was not disturbed. Two valid entries with the same peripheral id are placed far apart, and the search cycle count confirms that the lower one is returned.

// File: rtl/idx_pkg.sv
package idx_pkg;
  // Arbiter id width; the table has 2**AID_W entries.
  parameter int AID_W = 8;
  // Peripheral id width (slave address in the top 4 bits, number below).
  parameter int PID_W = 12;
  // Stored entry width and position of the valid flag.
  parameter int ENT_W = 16;
  parameter int VLD_POS = 15;

  localparam int NUM_ENT = 1 << AID_W;
  localparam int PAD_W = ENT_W - 1 - PID_W;
  localparam logic [AID_W:0] MISS_ID = (AID_W + 1)'(NUM_ENT);
  localparam logic [AID_W-1:0] TOP_ID = AID_W'(NUM_ENT - 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic             wrGo;
    logic [AID_W-1:0] probeAid;
    logic [PID_W-1:0] probeKey;
  } ctlStrobe_t;
endpackage

// File: rtl/idx_data.sv
module idx_data
  import idx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [AID_W:0]   wrAid,
  input  logic [ENT_W-1:0] wrPid,
  input  logic [AID_W-1:0] fwdAid,
  output logic [PID_W-1:0] fwdPid,
  output logic             fwdValid,
  output logic             probeHit,
  output logic             tblEmpty,
  output logic [AID_W-1:0] loAid,
  output logic [AID_W-1:0] hiAid,
  output logic             wrErr,
  output logic             wrDup
);
  logic [ENT_W-1:0] tbl [NUM_ENT];
  logic [ENT_W-1:0] fwdEnt;
  logic [ENT_W-1:0] prbEnt;
  logic [ENT_W-1:0] oldEnt;
  logic [AID_W-1:0] wIdx;
  logic             aidOk;
  logic             pidOk;
  logic             legal;

  assign wIdx  = wrAid[AID_W-1:0];
  assign aidOk = (wrAid < MISS_ID);
  assign pidOk = (wrPid[ENT_W-1:PID_W] == '0);
  assign legal = ctl.wrGo && aidOk && pidOk;

  assign oldEnt = tbl[wIdx];
  assign fwdEnt = tbl[fwdAid];
  assign prbEnt = tbl[ctl.probeAid];

  assign fwdPid   = fwdEnt[PID_W-1:0];
  assign fwdValid = fwdEnt[VLD_POS];
  assign probeHit = prbEnt[VLD_POS] && (prbEnt[PID_W-1:0] == ctl.probeKey);
  assign tblEmpty = (loAid > hiAid);

  // Entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) tbl[i] <= '0;
    end else if (legal) begin
      tbl[wIdx] <= {1'b1, PAD_W'(0), wrPid[PID_W-1:0]};
    end
  end

  // Bounds and write status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loAid <= TOP_ID;
      hiAid <= '0;
      wrErr <= 1'b0;
      wrDup <= 1'b0;
    end else if (ctl.wrGo) begin
      wrErr <= !(aidOk && pidOk);
      wrDup <= aidOk && pidOk && oldEnt[VLD_POS];
      if (aidOk && pidOk) begin
        if (wIdx < loAid) loAid <= wIdx;
        if (wIdx > hiAid) hiAid <= wIdx;
      end
    end
  end

  // R3
  bounds_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loAid == TOP_ID && hiAid == '0) |-> (loAid <= hiAid));

  // R5
  reject_keeps_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrGo && !(aidOk && pidOk)) |=> (wrErr && $stable(loAid) && $stable(hiAid)));

  // R4
  dup_needs_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDup |-> !wrErr);
endmodule

// File: rtl/idx_ctrl.sv
module idx_ctrl
  import idx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             revStart,
  input  logic [PID_W-1:0] revPid,
  input  logic             probeHit,
  input  logic             tblEmpty,
  input  logic [AID_W-1:0] loAid,
  input  logic [AID_W-1:0] hiAid,
  output ctlStrobe_t       ctl,
  output logic             wrReady,
  output logic             revBusy,
  output logic             revDone,
  output logic             revHit,
  output logic [AID_W:0]   revAid
);
  typedef enum logic {S_IDLE, S_SCAN} scanSt_t;

  scanSt_t          state;
  logic [AID_W-1:0] cursor;
  logic [PID_W-1:0] key;

  assign revBusy = (state == S_SCAN);
  assign wrReady = (state == S_IDLE) && !revStart;

  always_comb begin
    ctl.wrGo     = wrEn && wrReady;
    ctl.probeAid = cursor;
    ctl.probeKey = key;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cursor  <= '0;
      key     <= '0;
      revDone <= 1'b0;
      revHit  <= 1'b0;
      revAid  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (revStart) begin
            key    <= revPid;
            revHit <= 1'b0;
            if (tblEmpty) begin
              revDone <= 1'b1;
              revAid  <= MISS_ID;
            end else begin
              revDone <= 1'b0;
              cursor  <= loAid;
              state   <= S_SCAN;
            end
          end
        end
        S_SCAN: begin
          if (probeHit) begin
            revDone <= 1'b1;
            revHit  <= 1'b1;
            revAid  <= {1'b0, cursor};
            state   <= S_IDLE;
          end else if (cursor == hiAid) begin
            revDone <= 1'b1;
            revHit  <= 1'b0;
            revAid  <= MISS_ID;
            state   <= S_IDLE;
          end else begin
            cursor <= cursor + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  cursor_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN && $past(state) == S_SCAN) |-> (cursor == AID_W'($past(cursor) + 1'b1)));

  // R6
  hit_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (revDone && revHit) |-> (({1'b0, loAid} <= revAid) && (revAid <= {1'b0, hiAid})));

  // R7
  miss_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (revDone && !revHit) |-> (revAid == MISS_ID));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(revBusy && revDone));

  // R9
  no_write_in_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    revBusy |-> !ctl.wrGo);
endmodule

// File: rtl/idx_xlate_top.sv
module idx_xlate_top
  import idx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AID_W:0]   wrAid,
  input  logic [ENT_W-1:0] wrPid,
  output logic             wrReady,
  output logic             wrErr,
  output logic             wrDup,
  input  logic [AID_W-1:0] fwdAid,
  output logic [PID_W-1:0] fwdPid,
  output logic             fwdValid,
  input  logic             revStart,
  input  logic [PID_W-1:0] revPid,
  output logic             revBusy,
  output logic             revDone,
  output logic             revHit,
  output logic [AID_W:0]   revAid,
  output logic [AID_W-1:0] loAid,
  output logic [AID_W-1:0] hiAid
);
  ctlStrobe_t ctl;
  logic       probeHit;
  logic       tblEmpty;

  idx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .revStart(revStart), .revPid(revPid),
    .probeHit(probeHit), .tblEmpty(tblEmpty), .loAid(loAid), .hiAid(hiAid),
    .ctl(ctl), .wrReady(wrReady), .revBusy(revBusy), .revDone(revDone),
    .revHit(revHit), .revAid(revAid)
  );

  idx_data u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAid(wrAid), .wrPid(wrPid),
    .fwdAid(fwdAid), .fwdPid(fwdPid), .fwdValid(fwdValid), .probeHit(probeHit),
    .tblEmpty(tblEmpty), .loAid(loAid), .hiAid(hiAid), .wrErr(wrErr), .wrDup(wrDup)
  );
endmodule

// File: tb/sim_idx_xlate_top.sv
`timescale 1ns/1ps
module sim_idx_xlate_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAid = '0;
  logic [15:0] wrPid = '0;
  logic        wrReady, wrErr, wrDup;
  logic [7:0]  fwdAid = '0;
  logic [11:0] fwdPid;
  logic        fwdValid;
  logic        revStart = 1'b0;
  logic [11:0] revPid = '0;
  logic        revBusy, revDone, revHit;
  logic [8:0]  revAid;
  logic [7:0]  loAid, hiAid;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  idx_xlate_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAid(wrAid), .wrPid(wrPid),
    .wrReady(wrReady), .wrErr(wrErr), .wrDup(wrDup), .fwdAid(fwdAid),
    .fwdPid(fwdPid), .fwdValid(fwdValid), .revStart(revStart), .revPid(revPid),
    .revBusy(revBusy), .revDone(revDone), .revHit(revHit), .revAid(revAid),
    .loAid(loAid), .hiAid(hiAid)
  );

  typedef struct packed {
    logic [8:0]  aid;
    logic [15:0] pid;
    logic        err;
    logic        dup;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        fv;
    logic [11:0] fp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{9'h040, 16'h0130, 1'b0, 1'b0, 8'h40, 8'h40, 1'b1, 12'h130},
    '{9'h041, 16'h0131, 1'b0, 1'b0, 8'h40, 8'h41, 1'b1, 12'h131},
    '{9'h010, 16'h02A5, 1'b0, 1'b0, 8'h10, 8'h41, 1'b1, 12'h2A5},
    '{9'h0C0, 16'h0131, 1'b0, 1'b0, 8'h10, 8'hC0, 1'b1, 12'h131},
    '{9'h041, 16'h05FF, 1'b0, 1'b1, 8'h10, 8'hC0, 1'b1, 12'h5FF},
    '{9'h100, 16'h0111, 1'b1, 1'b0, 8'h10, 8'hC0, 1'b0, 12'h000},
    '{9'h050, 16'h1000, 1'b1, 1'b0, 8'h10, 8'hC0, 1'b0, 12'h000},
    '{9'h020, 16'h0FFF, 1'b0, 1'b0, 8'h10, 8'hC0, 1'b1, 12'hFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic progWrite(input logic [8:0] a, input logic [15:0] p);
    @(negedge clk);
    wrEn = 1'b1; wrAid = a; wrPid = p;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fwdCheck(input string tag, input logic [7:0] a, input logic v, input logic [11:0] p);
    fwdAid = a;
    #0.5;
    check({tag, " fwdValid"}, 32'(fwdValid), 32'(v));
    check({tag, " fwdPid"}, 32'(fwdPid), 32'(p));
  endtask

  task automatic search(input logic [11:0] pid, input logic [8:0] eAid, input logic eHit,
                        input int eCyc, input bit disturb, input string tag);
    int cyc;
    @(negedge clk);
    revPid = pid; revStart = 1'b1;
    if (disturb) begin
      wrEn = 1'b1; wrAid = 9'h071; wrPid = 16'h0444;
      #0.5 check("R9 wrReady low with start", 32'(wrReady), 32'h0);
    end
    @(negedge clk);
    revStart = 1'b0; wrEn = 1'b0; cyc = 0;
    while (!revDone && cyc < 1000) begin
      if (disturb && cyc == 5) begin
        wrEn = 1'b1; wrAid = 9'h070; wrPid = 16'h0333;
        #0.5 check("R9 wrReady low while busy", 32'(wrReady), 32'h0);
        check("R8 busy during scan", 32'(revBusy), 32'h1);
      end
      if (disturb && cyc == 6) wrEn = 1'b0;
      if (disturb && cyc == 10) begin revStart = 1'b1; revPid = 12'h2A5; end
      if (disturb && cyc == 11) revStart = 1'b0;
      @(negedge clk);
      cyc++;
    end
    check({tag, " cycles"}, 32'(cyc), 32'(eCyc));
    check({tag, " revAid"}, 32'(revAid), 32'(eAid));
    check({tag, " revHit"}, 32'(revHit), 32'(eHit));
    check({tag, " busy at done"}, 32'(revBusy), 32'h0);
    repeat (5) @(negedge clk);
    check("R8 result held", 32'({revDone, revAid}), 32'({1'b1, eAid}));
    if (disturb) begin
      fwdCheck("R9 stalled write 0x70", 8'h70, 1'b0, 12'h000);
      fwdCheck("R9 stalled write 0x71", 8'h71, 1'b0, 12'h000);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1 reset state
    check("R1 loAid", 32'(loAid), 32'hFF);
    check("R1 hiAid", 32'(hiAid), 32'h00);
    check("R1 wrReady", 32'(wrReady), 32'h1);
    check("R1 flags", 32'({wrErr, wrDup, revBusy, revDone, revHit}), 32'h0);
    check("R1 revAid", 32'(revAid), 32'h0);
    fwdCheck("R1 entry 0x40", 8'h40, 1'b0, 12'h000);
    fwdCheck("R1 entry 0xFF", 8'hFF, 1'b0, 12'h000);

    // R7 empty table: result at the start edge
    search(12'h130, 9'h100, 1'b0, 0, 1'b0, "R7 empty");

    // Vector walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      progWrite(VEC[i].aid, VEC[i].pid);
      #0.5;
      check($sformatf("R5 wrErr vec%0d", i), 32'(wrErr), 32'(VEC[i].err));
      check($sformatf("R4 wrDup vec%0d", i), 32'(wrDup), 32'(VEC[i].dup));
      check($sformatf("R3 loAid vec%0d", i), 32'(loAid), 32'(VEC[i].lo));
      check($sformatf("R3 hiAid vec%0d", i), 32'(hiAid), 32'(VEC[i].hi));
      fwdCheck($sformatf("R2 fwd vec%0d", i), VEC[i].aid[7:0], VEC[i].fv, VEC[i].fp);
    end
    fwdCheck("R4 overwritten 0x41", 8'h41, 1'b1, 12'h5FF);

    // R6 match at the low bound
    search(12'h2A5, 9'h010, 1'b1, 1, 1'b0, "R6 first entry");
    // R6 single match far up
    search(12'h131, 9'h0C0, 1'b1, 177, 1'b0, "R6 far match");
    // R6 lowest of two matches wins
    progWrite(9'h060, 16'h0131);
    search(12'h131, 9'h060, 1'b1, 81, 1'b0, "R6 lowest first");
    // R7 miss over full window
    search(12'h777, 9'h100, 1'b0, 177, 1'b0, "R7 miss");
    // R10 never-programmed entries hold 0 but do not match
    search(12'h000, 9'h100, 1'b0, 177, 1'b0, "R10 unprogrammed");
    // R8 R9 disturbances during a long miss
    search(12'h777, 9'h100, 1'b0, 177, 1'b1, "R8 disturbed miss");
    // Writes work again after the scan
    progWrite(9'h0FF, 16'h0ABC);
    #0.5;
    check("R3 hiAid top", 32'(hiAid), 32'hFF);
    fwdCheck("R2 top entry", 8'hFF, 1'b1, 12'hABC);
    search(12'hABC, 9'h0FF, 1'b1, 240, 1'b0, "R6 top entry");

    finishRun();
  end
endmodule